// File: doc/BRIEF.md
# Low-Power Mode Clock Controller

This block decides which clock groups of a small controller-class system are allowed to run. It tracks five operating modes (Run, Wait, Stop, Standby, Power-Down). It drives one enable for the core and memory clocks, one enable per peripheral, an enable for master clock generation, and the control levels that step the clock source, PLL, oscillator and regulator into and out of their low-power states.

Wait and Stop are entered from full-speed Run by instruction strobes. Each of the two modes has its own set of wake sources, and a per-peripheral mask selects which interrupts may wake from Stop. Standby and Power-Down are reached through a step sequence that software drives with level control bits. Each step is accepted only in its turn. The way back undoes the steps in reverse order, and the last step waits for PLL lock before full-speed clocking returns. All state changes happen on the clock edge that samples the cause, so results are visible one cycle after a stimulus.

Top module: `lpm_clk_ctrl`

## Requirements
- R1: `rst`, or any bit of `rst_src` (bit 0 external, bit 1 software, bit 2 watchdog), clears the controller on the next edge. Power-Down is the exception described in R12. After the clear, `mode_o` reads Run and every low-power control output is 0.
- R2: `mode_o` encodes Run=0, Wait=1, Stop=2, Standby=3, Power-Down=4. In Run, `core_clk_en`, every bit of `periph_clk_en` and `master_gen_en` are 1.
- R3: When `wait_stb` is seen in Run at full speed (`lowspeed_sel`=0), the mode becomes Wait on the next edge. In Wait, `core_clk_en` is 0 and all peripheral enables stay 1.
- R4: Wait returns to Run one edge after any set bit of `irq_vec`, `lvi_irq`, `dbg_req` or any reset source.
- R5: When `stop_stb` is seen in Run at full speed, the mode becomes Stop on the next edge. In Stop, `core_clk_en` is 0 and `master_gen_en` stays 1. If both strobes arrive in the same cycle, Stop is chosen.
- R6: Stop returns to Run one edge after an interrupt on a peripheral whose `stop_wake_en` bit is set, `lvi_irq`, `dbg_req` or any reset source. Interrupts on unmasked peripherals leave the mode at Stop.
- R7: In Stop, `periph_clk_en[i]` equals `stop_keep[i]` for each peripheral i.
- R8: While the core runs, the standby steps advance one per edge, and only in this order: `cfg_lowspeed` sets `lowspeed_sel`, then `cfg_pll_pd` sets `pll_pd`, then `cfg_osc_stby` sets `osc_stby`, then `cfg_reg_stby` sets `reg_stby`, which gives Standby. A control bit set out of turn has no effect.
- R9: In Standby, `core_clk_en` and all peripheral enables are 1, `sys_div2` is 1 and `hs_periph_ok` is 0. Wait and stop strobes are ignored, so the mode stays Standby.
- R10: Exit undoes the steps in reverse order as their control bits clear, and leaving Standby shows Run mode. `lowspeed_sel` drops only on an edge where `pll_lock` is 1. After that, `hs_periph_ok` is 1 and `sys_div2` is 0.
- R11: Setting `cfg_osc_pd` in Standby leads to Power-Down on the next edge. There `osc_pd` is 1, and `core_clk_en`, all peripheral enables and `master_gen_en` are 0.
- R12: Only `rst` or external reset (`rst_src` bit 0) leaves Power-Down. Software or watchdog reset, interrupts, `lvi_irq` and `dbg_req` leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| rst_src | input | 3 | Reset sources: bit 0 external, bit 1 software, bit 2 watchdog |
| wait_stb | input | 1 | Wait instruction strobe |
| stop_stb | input | 1 | Stop instruction strobe |
| irq_vec | input | NPERIPH | Per-peripheral interrupt requests |
| stop_wake_en | input | NPERIPH | Peripherals allowed to wake from Stop |
| stop_keep | input | NPERIPH | Peripherals whose clock keeps running in Stop |
| lvi_irq | input | 1 | Low-voltage interrupt |
| dbg_req | input | 1 | Debug entry request |
| cfg_lowspeed | input | 1 | Step control: select low-speed source |
| cfg_pll_pd | input | 1 | Step control: power down PLL |
| cfg_osc_stby | input | 1 | Step control: oscillator standby |
| cfg_reg_stby | input | 1 | Step control: regulator standby |
| cfg_osc_pd | input | 1 | Step control: oscillator power-down |
| pll_lock | input | 1 | PLL lock indication |
| mode_o | output | 3 | Current mode code |
| core_clk_en | output | 1 | Core and memory clock enable |
| periph_clk_en | output | NPERIPH | Per-peripheral clock enables |
| master_gen_en | output | 1 | Master clock generation enable |
| pll_pd | output | 1 | PLL power-down |
| lowspeed_sel | output | 1 | Low-speed clock source selected |
| osc_stby | output | 1 | Oscillator in standby |
| reg_stby | output | 1 | Regulator in standby |
| osc_pd | output | 1 | Oscillator powered down |
| sys_div2 | output | 1 | System clocks divided by two |
| hs_periph_ok | output | 1 | High-speed peripheral clock option available |

## Verification
Every state register here sits one edge away from its cause. A strobe, wake source, reset or step control applied in one cycle therefore shows on the outputs right after the next rising edge. The outputs are decoded from state without another register stage. The bench changes its inputs shortly after a rising edge, lets exactly one edge pass, and samples 1 ns after that edge. Where an input must be ignored (an unmasked interrupt in Stop, a soft reset in Power-Down, a step out of turn, a missing PLL lock), it samples one and sometimes two edges later and expects the earlier outputs unchanged.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    typedef enum logic [2:0] {
        MD_RUN  = 3'd0,
        MD_WAIT = 3'd1,
        MD_STOP = 3'd2,
        MD_STBY = 3'd3,
        MD_PDN  = 3'd4
    } mode_e;

    typedef enum logic [1:0] {
        CS_ACTIVE = 2'd0,
        CS_WAIT   = 2'd1,
        CS_STOP   = 2'd2
    } core_st_e;

    typedef enum logic [2:0] {
        SQ_FULL   = 3'd0,
        SQ_SLOW   = 3'd1,
        SQ_PLLOFF = 3'd2,
        SQ_OSCSB  = 3'd3,
        SQ_STBY   = 3'd4,
        SQ_PDN    = 3'd5
    } seq_e;

    localparam int RS_EXT  = 0;
    localparam int RS_SW   = 1;
    localparam int RS_WDOG = 2;
    localparam int RS_W    = 3;

    typedef struct packed {
        logic lowspeed;
        logic pll_pd;
        logic osc_stby;
        logic reg_stby;
        logic osc_pd;
    } seq_cfg_t;

    typedef struct packed {
        logic from_wait;
        logic from_stop;
    } wake_t;

    typedef struct packed {
        logic lowspeed;
        logic pll_pd;
        logic osc_stby;
        logic reg_stby;
        logic osc_pd;
        logic div2;
        logic hs_ok;
    } seq_out_t;

    function automatic mode_e mode_of(core_st_e c, seq_e s);
        mode_e m;
        if (s == SQ_PDN)       m = MD_PDN;
        else if (s == SQ_STBY) m = MD_STBY;
        else if (c == CS_WAIT) m = MD_WAIT;
        else if (c == CS_STOP) m = MD_STOP;
        else                   m = MD_RUN;
        return m;
    endfunction

    function automatic seq_out_t seq_decode(seq_e s);
        seq_out_t o;
        o.lowspeed = (s >= SQ_SLOW);
        o.pll_pd   = (s >= SQ_PLLOFF);
        o.osc_stby = (s >= SQ_OSCSB);
        o.reg_stby = (s >= SQ_STBY);
        o.osc_pd   = (s == SQ_PDN);
        o.div2     = (s >= SQ_SLOW) && (s != SQ_PDN);
        o.hs_ok    = (s == SQ_FULL);
        return o;
    endfunction

endpackage

// File: rtl/lpm_wake.sv
module lpm_wake
    import lpm_pkg::*;
#(
    parameter int NPERIPH = 8
) (
    input  logic [NPERIPH-1:0] irq_vec,
    input  logic [NPERIPH-1:0] stop_wake_en,
    input  logic               lvi_irq,
    input  logic               dbg_req,
    output wake_t              wake
);
    logic [NPERIPH-1:0] masked;

    genvar g;
    generate
        for (g = 0; g < NPERIPH; g++) begin : g_mask
            assign masked[g] = irq_vec[g] & stop_wake_en[g];
        end
    endgenerate

    always_comb begin
        wake.from_wait = (|irq_vec) | lvi_irq | dbg_req;
        wake.from_stop = (|masked)  | lvi_irq | dbg_req;
    end
endmodule

// File: rtl/lpm_core_fsm.sv
module lpm_core_fsm
    import lpm_pkg::*;
(
    input  logic     clk,
    input  logic     clr,
    input  logic     allow,
    input  logic     wait_stb,
    input  logic     stop_stb,
    input  wake_t    wake,
    output core_st_e state
);
    core_st_e nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            CS_ACTIVE: begin
                if (allow && stop_stb)      nxt = CS_STOP;
                else if (allow && wait_stb) nxt = CS_WAIT;
            end
            CS_WAIT: if (wake.from_wait) nxt = CS_ACTIVE;
            CS_STOP: if (wake.from_stop) nxt = CS_ACTIVE;
            default: nxt = CS_ACTIVE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (clr) state <= CS_ACTIVE;
        else     state <= nxt;
    end
endmodule

// File: rtl/lpm_stby_seq.sv
module lpm_stby_seq
    import lpm_pkg::*;
(
    input  logic     clk,
    input  logic     clr,
    input  logic     run_ok,
    input  seq_cfg_t cfg,
    input  logic     pll_lock,
    output seq_e     step
);
    seq_e nxt;

    always_comb begin
        nxt = step;
        if (run_ok) begin
            unique case (step)
                SQ_FULL:   if (cfg.lowspeed) nxt = SQ_SLOW;
                SQ_SLOW: begin
                    if (cfg.pll_pd)                      nxt = SQ_PLLOFF;
                    else if (!cfg.lowspeed && pll_lock)  nxt = SQ_FULL;
                end
                SQ_PLLOFF: begin
                    if (cfg.osc_stby)     nxt = SQ_OSCSB;
                    else if (!cfg.pll_pd) nxt = SQ_SLOW;
                end
                SQ_OSCSB: begin
                    if (cfg.reg_stby)       nxt = SQ_STBY;
                    else if (!cfg.osc_stby) nxt = SQ_PLLOFF;
                end
                SQ_STBY: begin
                    if (cfg.osc_pd)         nxt = SQ_PDN;
                    else if (!cfg.reg_stby) nxt = SQ_OSCSB;
                end
                SQ_PDN:    nxt = SQ_PDN;
                default:   nxt = SQ_FULL;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (clr) step <= SQ_FULL;
        else     step <= nxt;
    end
endmodule

// File: rtl/lpm_clk_gate.sv
module lpm_clk_gate
    import lpm_pkg::*;
#(
    parameter int NPERIPH = 8
) (
    input  mode_e              mode,
    input  seq_e               step,
    input  logic [NPERIPH-1:0] stop_keep,
    output logic               core_clk_en,
    output logic [NPERIPH-1:0] periph_clk_en,
    output logic               master_gen_en,
    output seq_out_t           sq
);
    logic grp_on;

    assign grp_on        = (mode == MD_RUN) || (mode == MD_WAIT) || (mode == MD_STBY);
    assign core_clk_en   = (mode == MD_RUN) || (mode == MD_STBY);
    assign master_gen_en = (mode != MD_PDN);
    assign sq            = seq_decode(step);

    genvar g;
    generate
        for (g = 0; g < NPERIPH; g++) begin : g_per
            assign periph_clk_en[g] = grp_on | ((mode == MD_STOP) & stop_keep[g]);
        end
    endgenerate
endmodule

// File: rtl/lpm_clk_ctrl.sv
module lpm_clk_ctrl
    import lpm_pkg::*;
#(
    parameter int NPERIPH = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [2:0]         rst_src,
    input  logic               wait_stb,
    input  logic               stop_stb,
    input  logic [NPERIPH-1:0] irq_vec,
    input  logic [NPERIPH-1:0] stop_wake_en,
    input  logic [NPERIPH-1:0] stop_keep,
    input  logic               lvi_irq,
    input  logic               dbg_req,
    input  logic               cfg_lowspeed,
    input  logic               cfg_pll_pd,
    input  logic               cfg_osc_stby,
    input  logic               cfg_reg_stby,
    input  logic               cfg_osc_pd,
    input  logic               pll_lock,
    output logic [2:0]         mode_o,
    output logic               core_clk_en,
    output logic [NPERIPH-1:0] periph_clk_en,
    output logic               master_gen_en,
    output logic               pll_pd,
    output logic               lowspeed_sel,
    output logic               osc_stby,
    output logic               reg_stby,
    output logic               osc_pd,
    output logic               sys_div2,
    output logic               hs_periph_ok
);
    core_st_e core_st;
    seq_e     step;
    mode_e    mode;
    wake_t    wake;
    seq_cfg_t cfg;
    seq_out_t sq;
    logic     hard_clr, soft_clr, clr;

    assign hard_clr = rst | rst_src[RS_EXT];
    assign soft_clr = (rst_src[RS_SW] | rst_src[RS_WDOG]) & (step != SQ_PDN);
    assign clr      = hard_clr | soft_clr;

    assign cfg = '{lowspeed: cfg_lowspeed, pll_pd: cfg_pll_pd,
                   osc_stby: cfg_osc_stby, reg_stby: cfg_reg_stby,
                   osc_pd:   cfg_osc_pd};

    lpm_wake #(.NPERIPH(NPERIPH)) u_wake (
        .irq_vec      (irq_vec),
        .stop_wake_en (stop_wake_en),
        .lvi_irq      (lvi_irq),
        .dbg_req      (dbg_req),
        .wake         (wake)
    );

    lpm_core_fsm u_fsm (
        .clk      (clk),
        .clr      (clr),
        .allow    (step == SQ_FULL),
        .wait_stb (wait_stb),
        .stop_stb (stop_stb),
        .wake     (wake),
        .state    (core_st)
    );

    lpm_stby_seq u_seq (
        .clk      (clk),
        .clr      (clr),
        .run_ok   (core_st == CS_ACTIVE),
        .cfg      (cfg),
        .pll_lock (pll_lock),
        .step     (step)
    );

    assign mode = mode_of(core_st, step);

    lpm_clk_gate #(.NPERIPH(NPERIPH)) u_gate (
        .mode          (mode),
        .step          (step),
        .stop_keep     (stop_keep),
        .core_clk_en   (core_clk_en),
        .periph_clk_en (periph_clk_en),
        .master_gen_en (master_gen_en),
        .sq            (sq)
    );

    assign mode_o       = mode;
    assign lowspeed_sel = sq.lowspeed;
    assign pll_pd       = sq.pll_pd;
    assign osc_stby     = sq.osc_stby;
    assign reg_stby     = sq.reg_stby;
    assign osc_pd       = sq.osc_pd;
    assign sys_div2     = sq.div2;
    assign hs_periph_ok = sq.hs_ok;
endmodule

// File: rtl/lpm_clk_ctrl_chk.sv
module lpm_clk_ctrl_chk #(
    parameter int NPERIPH = 8
) (
    input logic               clk,
    input logic               rst,
    input logic [2:0]         rst_src,
    input logic               wait_stb,
    input logic               stop_stb,
    input logic [NPERIPH-1:0] irq_vec,
    input logic [NPERIPH-1:0] stop_wake_en,
    input logic [NPERIPH-1:0] stop_keep,
    input logic               lvi_irq,
    input logic               dbg_req,
    input logic               pll_lock,
    input logic [2:0]         mode_o,
    input logic               core_clk_en,
    input logic [NPERIPH-1:0] periph_clk_en,
    input logic               master_gen_en,
    input logic               lowspeed_sel
);
    // R1
    ext_rst_run_chk: assert property (@(posedge clk) disable iff (rst)
        rst_src[0] |=> (mode_o == 3'd0));

    // R3
    wait_enter_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_o == 3'd0 && !lowspeed_sel && wait_stb && !stop_stb && rst_src == 3'b000)
        |=> (mode_o == 3'd1));

    // R6
    stop_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_o == 3'd2 && (irq_vec & stop_wake_en) == '0 && !lvi_irq && !dbg_req
         && rst_src == 3'b000) |=> (mode_o == 3'd2));

    // R7
    stop_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_o == 3'd2) |-> (!core_clk_en && master_gen_en
                              && (periph_clk_en & ~stop_keep) == '0));

    // R10
    lock_gate_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(lowspeed_sel) && !$past(rst) && $past(rst_src) == 3'b000)
        |-> $past(pll_lock));

    // R11
    pdn_off_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_o == 3'd4) |-> (!core_clk_en && !master_gen_en && periph_clk_en == '0));

    // R12
    pdn_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_o == 3'd4 && !rst_src[0]) |=> (mode_o == 3'd4));
endmodule

bind lpm_clk_ctrl lpm_clk_ctrl_chk #(.NPERIPH(NPERIPH)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .rst_src       (rst_src),
    .wait_stb      (wait_stb),
    .stop_stb      (stop_stb),
    .irq_vec       (irq_vec),
    .stop_wake_en  (stop_wake_en),
    .stop_keep     (stop_keep),
    .lvi_irq       (lvi_irq),
    .dbg_req       (dbg_req),
    .pll_lock      (pll_lock),
    .mode_o        (mode_o),
    .core_clk_en   (core_clk_en),
    .periph_clk_en (periph_clk_en),
    .master_gen_en (master_gen_en),
    .lowspeed_sel  (lowspeed_sel)
);

// File: tb/sim_lpm_clk_ctrl.sv
`timescale 1ns/1ps
module sim_lpm_clk_ctrl;
    localparam int NP = 8;

    logic          clk = 1'b0;
    logic          rst;
    logic [2:0]    rst_src;
    logic          wait_stb, stop_stb, lvi_irq, dbg_req, pll_lock;
    logic [NP-1:0] irq_vec, stop_wake_en, stop_keep;
    logic          cfg_lowspeed, cfg_pll_pd, cfg_osc_stby, cfg_reg_stby, cfg_osc_pd;
    logic [2:0]    mode_o;
    logic          core_clk_en, master_gen_en, pll_pd, lowspeed_sel;
    logic          osc_stby, reg_stby, osc_pd, sys_div2, hs_periph_ok;
    logic [NP-1:0] periph_clk_en;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    lpm_clk_ctrl #(.NPERIPH(NP)) u0 (
        .clk(clk), .rst(rst), .rst_src(rst_src), .wait_stb(wait_stb), .stop_stb(stop_stb),
        .irq_vec(irq_vec), .stop_wake_en(stop_wake_en), .stop_keep(stop_keep),
        .lvi_irq(lvi_irq), .dbg_req(dbg_req), .cfg_lowspeed(cfg_lowspeed),
        .cfg_pll_pd(cfg_pll_pd), .cfg_osc_stby(cfg_osc_stby), .cfg_reg_stby(cfg_reg_stby),
        .cfg_osc_pd(cfg_osc_pd), .pll_lock(pll_lock), .mode_o(mode_o),
        .core_clk_en(core_clk_en), .periph_clk_en(periph_clk_en),
        .master_gen_en(master_gen_en), .pll_pd(pll_pd), .lowspeed_sel(lowspeed_sel),
        .osc_stby(osc_stby), .reg_stby(reg_stby), .osc_pd(osc_pd),
        .sys_div2(sys_div2), .hs_periph_ok(hs_periph_ok)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_inputs();
        rst_src = '0; wait_stb = 0; stop_stb = 0; lvi_irq = 0; dbg_req = 0;
        irq_vec = '0; cfg_lowspeed = 0; cfg_pll_pd = 0; cfg_osc_stby = 0;
        cfg_reg_stby = 0; cfg_osc_pd = 0;
    endtask

    task automatic t_reset_run();
        rst = 1; clear_inputs(); pll_lock = 1;
        stop_wake_en = 8'h02; stop_keep = 8'h05;
        tick(); tick();
        chk("R1 mode after rst", mode_o, 0);
        chk("R1 lowspeed after rst", lowspeed_sel, 0);
        chk("R1 pll_pd after rst", pll_pd, 0);
        rst = 0; tick();
        chk("R2 core on", core_clk_en, 1);
        chk("R2 periph on", periph_clk_en, 8'hFF);
        chk("R2 master on", master_gen_en, 1);
        chk("R2 hs ok", hs_periph_ok, 1);
    endtask

    task automatic enter_wait();
        wait_stb = 1; tick(); wait_stb = 0;
    endtask

    task automatic t_wait();
        enter_wait();
        chk("R3 mode wait", mode_o, 1);
        chk("R3 core off", core_clk_en, 0);
        chk("R3 periph on", periph_clk_en, 8'hFF);
        tick();
        chk("R3 stays wait", mode_o, 1);
        lvi_irq = 1; tick(); lvi_irq = 0;
        chk("R4 lvi wake", mode_o, 0);
        enter_wait();
        irq_vec = 8'h10; tick(); irq_vec = '0;
        chk("R4 irq wake", mode_o, 0);
        enter_wait();
        dbg_req = 1; tick(); dbg_req = 0;
        chk("R4 dbg wake", mode_o, 0);
        enter_wait();
        rst_src = 3'b010; tick(); rst_src = '0;
        chk("R4 sw reset wake", mode_o, 0);
    endtask

    task automatic enter_stop();
        stop_stb = 1; tick(); stop_stb = 0;
    endtask

    task automatic t_stop();
        stop_stb = 1; wait_stb = 1; tick(); stop_stb = 0; wait_stb = 0;
        chk("R5 stop wins", mode_o, 2);
        chk("R5 core off", core_clk_en, 0);
        chk("R5 master on", master_gen_en, 1);
        chk("R7 periph keep", periph_clk_en, 8'h05);
        irq_vec = 8'h01; tick(); irq_vec = '0;
        chk("R6 unmasked ignored", mode_o, 2);
        chk("R7 periph keep held", periph_clk_en, 8'h05);
        irq_vec = 8'h02; tick(); irq_vec = '0;
        chk("R6 masked wake", mode_o, 0);
        enter_stop();
        lvi_irq = 1; tick(); lvi_irq = 0;
        chk("R6 lvi wake", mode_o, 0);
        enter_stop();
        rst_src = 3'b100; tick(); rst_src = '0;
        chk("R6 wdog wake", mode_o, 0);
        stop_keep = 8'hA0; enter_stop();
        chk("R7 other keep mask", periph_clk_en, 8'hA0);
        dbg_req = 1; tick(); dbg_req = 0;
        chk("R6 dbg wake", mode_o, 0);
    endtask

    task automatic t_standby();
        cfg_pll_pd = 1; tick();
        chk("R8 out of turn pll", pll_pd, 0);
        chk("R8 out of turn slow", lowspeed_sel, 0);
        cfg_pll_pd = 0; cfg_lowspeed = 1; tick();
        chk("R8 slow step", lowspeed_sel, 1);
        chk("R8 pll still on", pll_pd, 0);
        chk("R8 hs gone", hs_periph_ok, 0);
        cfg_pll_pd = 1; tick();
        chk("R8 pll step", pll_pd, 1);
        cfg_osc_stby = 1; tick();
        chk("R8 osc step", osc_stby, 1);
        chk("R8 not standby yet", mode_o, 0);
        cfg_reg_stby = 1; tick();
        chk("R8 standby mode", mode_o, 3);
        chk("R8 reg step", reg_stby, 1);
        chk("R9 core on", core_clk_en, 1);
        chk("R9 periph on", periph_clk_en, 8'hFF);
        chk("R9 div2", sys_div2, 1);
        chk("R9 hs off", hs_periph_ok, 0);
        wait_stb = 1; tick(); wait_stb = 0;
        chk("R9 wait ignored", mode_o, 3);
        stop_stb = 1; tick(); stop_stb = 0;
        chk("R9 stop ignored", mode_o, 3);
        cfg_reg_stby = 0; tick();
        chk("R10 reg off", reg_stby, 0);
        chk("R10 run mode", mode_o, 0);
        chk("R10 osc still stby", osc_stby, 1);
        cfg_osc_stby = 0; tick();
        chk("R10 osc off", osc_stby, 0);
        cfg_pll_pd = 0; tick();
        chk("R10 pll up", pll_pd, 0);
        pll_lock = 0; cfg_lowspeed = 0; tick();
        chk("R10 wait for lock", lowspeed_sel, 1);
        tick();
        chk("R10 still no lock", lowspeed_sel, 1);
        pll_lock = 1; tick();
        chk("R10 full speed", lowspeed_sel, 0);
        chk("R10 hs back", hs_periph_ok, 1);
        chk("R10 div2 off", sys_div2, 0);
        cfg_lowspeed = 1; tick(); cfg_pll_pd = 1; tick();
        cfg_lowspeed = 0; cfg_pll_pd = 0;
        rst_src = 3'b010; tick(); rst_src = '0;
        chk("R1 sw reset clears slow", lowspeed_sel, 0);
        chk("R1 sw reset clears pll", pll_pd, 0);
    endtask

    task automatic enter_pdn();
        cfg_lowspeed = 1; cfg_pll_pd = 1; cfg_osc_stby = 1; cfg_reg_stby = 1; cfg_osc_pd = 1;
        for (int i = 0; i < 5; i++) tick();
        clear_inputs();
    endtask

    task automatic t_pdn();
        enter_pdn();
        chk("R11 pdn mode", mode_o, 4);
        chk("R11 osc_pd", osc_pd, 1);
        chk("R11 core off", core_clk_en, 0);
        chk("R11 periph off", periph_clk_en, 8'h00);
        chk("R11 master off", master_gen_en, 0);
        rst_src = 3'b010; tick(); rst_src = '0;
        chk("R12 sw reset ignored", mode_o, 4);
        rst_src = 3'b100; tick(); rst_src = '0;
        chk("R12 wdog ignored", mode_o, 4);
        irq_vec = 8'hFF; lvi_irq = 1; dbg_req = 1; tick(); clear_inputs();
        chk("R12 wake ignored", mode_o, 4);
        rst_src = 3'b001; tick(); rst_src = '0;
        chk("R12 ext exit", mode_o, 0);
        chk("R12 osc_pd clear", osc_pd, 0);
        chk("R1 master back", master_gen_en, 1);
        enter_pdn();
        rst = 1; tick(); rst = 0;
        chk("R12 por exit", mode_o, 0);
    endtask

    initial begin
        t_reset_run();
        t_wait();
        t_stop();
        t_standby();
        t_pdn();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #100000;
        total++; bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule